// File: doc/BRIEF.md
# Bank-Crossing Wait-State Inserter

This block sits between a processor core and its external memory port and decides, for every program or data access, whether one extra cycle is needed before the access may complete. An extra cycle is added when the access falls in a different memory bank from the access before it. One is also added when the access moves from data space into program space. When the switch feature is enabled, one is added when a read follows a read of the other space. No access ever gets more than one added cycle.

A 16-bit control word sits on a small register bus at address 0x29. It sets which upper address bits define a bank and turns the read-switch rule on or off. It also drives two bus-holder enables and a bus-off bit. Bus-off parks the external interface once the access in flight has finished. The core holds an access request, with its address, space and direction, stable until the ready output is high at a clock edge. That edge completes the access.

Top module: `bank_wait_inserter`

## Requirements
- R1: After reset the control word reads 0xF800: bank mask in bits 15:12 is 1111, read-switch enable in bit 11 is 1, host-holder enable (bit 2), data-holder enable (bit 1) and bus-off (bit 0) are 0. With no request pending, `acc_ready` is 0 and `bus_en` is 1.
- R2: The first access after reset completes in its first cycle, with no inserted wait.
- R3: An access in the same space as the previous completed access gets one wait cycle when address bits 15:12, ANDed with the bank mask, differ from those of the previous access. A mask of 0000 never causes a bank wait.
- R4: An access to program space (`acc_prog`=1) whose previous completed access was to data space gets one wait cycle. This applies to reads and writes alike.
- R5: When bit 11 is 1, a read following a read of the other space gets one wait cycle. When bit 11 is 0, that transition adds nothing.
- R6: A wait holds `acc_ready` low for exactly one clock. An access never gets more than one wait, even when several rules apply.
- R7: Control bits 10:3 always read 0, and writes to them are ignored. A write to any register address other than 0x29 changes nothing, and such addresses read 0.
- R8: `hold_host_en` follows bit 2 and `hold_data_en` follows bit 1 of the control word.
- R9: While bit 0 is 1 and no access is in flight, `bus_en` is 0 and requests are stalled with `acc_ready` low. Once the bit is cleared, the stalled request proceeds under R3 to R6.
- R10: If bus-off is set while an access is in its wait cycle, that access still completes with `bus_en` held 1. `bus_en` falls after the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmr_addr | input | 8 | Register bus address |
| mmr_wr | input | 1 | Register write strobe |
| mmr_wdata | input | 16 | Register write data |
| mmr_rdata | output | 16 | Register read data (control word at 0x29, else 0) |
| acc_req | input | 1 | Access request, held until ready |
| acc_addr | input | 16 | Access address |
| acc_prog | input | 1 | 1 = program space, 0 = data space |
| acc_read | input | 1 | 1 = read, 0 = write |
| acc_ready | output | 1 | Access completes at this clock edge |
| bus_en | output | 1 | External interface active |
| hold_host_en | output | 1 | Host-port bus holder enable |
| hold_data_en | output | 1 | Data bus holder enable |

## Verification
Two functions can land on the same cycle. An access can enter its inserted wait while a register write sets the bus-off bit. The bench provokes this by issuing a bank-crossing access and the bus-off write on the same clock. It then judges that the wait cycle still ends with ready high and `bus_en` high, and that `bus_en` drops on the next cycle, where a new request stalls. A second overlap comes from accesses that satisfy the bank, data-to-program and read-switch rules at once. The bench judges these by counting exactly one low-ready cycle.

// File: rtl/bwi_pkg.sv
package bwi_pkg;

  localparam int BANK_W = 4;

  typedef struct packed {
    logic              valid;
    logic [BANK_W-1:0] hi;
    logic              prog;
    logic              read;
  } hist_t;

  // Bank rule: same space, masked upper bits differ.
  function automatic logic bank_cross(hist_t h, logic [BANK_W-1:0] hi,
                                      logic prog, logic [BANK_W-1:0] mask);
    return h.valid && (h.prog == prog) && (((h.hi ^ hi) & mask) != '0);
  endfunction

  // Space rule: data access followed by program access.
  function automatic logic space_cross(hist_t h, logic prog);
    return h.valid && !h.prog && prog;
  endfunction

  // Read-switch rule: read of one space after read of the other.
  function automatic logic read_switch(hist_t h, logic prog, logic read,
                                       logic sw_en);
    return sw_en && h.valid && h.read && read && (h.prog != prog);
  endfunction

endpackage

// File: rtl/bwi_cfg_reg.sv
module bwi_cfg_reg #(
  parameter int          MMR_AW   = 8,
  parameter logic [7:0]  CFG_ADDR = 8'h29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MMR_AW-1:0] mmr_addr,
  input  logic              mmr_wr,
  input  logic [15:0]       mmr_wdata,
  output logic [15:0]       mmr_rdata,
  output logic [bwi_pkg::BANK_W-1:0] mask,
  output logic              sw_en,
  output logic              host_hold,
  output logic              data_hold,
  output logic              bus_off
);
  import bwi_pkg::*;

  localparam logic [15:0] RESET_WORD = 16'hF800;

  logic hit;
  logic [15:0] word;
  assign hit = (mmr_addr == CFG_ADDR[MMR_AW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= RESET_WORD[15 -: BANK_W];
      sw_en     <= RESET_WORD[11];
      host_hold <= 1'b0;
      data_hold <= 1'b0;
      bus_off   <= 1'b0;
    end else if (mmr_wr && hit) begin
      mask      <= mmr_wdata[15 -: BANK_W];
      sw_en     <= mmr_wdata[11];
      host_hold <= mmr_wdata[2];
      data_hold <= mmr_wdata[1];
      bus_off   <= mmr_wdata[0];
    end
  end

  always_comb begin
    word = '0;
    word[15 -: BANK_W] = mask;
    word[11] = sw_en;
    word[2]  = host_hold;
    word[1]  = data_hold;
    word[0]  = bus_off;
  end

  assign mmr_rdata = hit ? word : 16'h0000;

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mmr_rdata[10:3] == 8'h00);

  assert_miss_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mmr_wr && !hit) |=> $stable(word));

endmodule

// File: rtl/bwi_history.sv
module bwi_history (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       complete,
  input  logic [bwi_pkg::BANK_W-1:0] hi,
  input  logic                       prog,
  input  logic                       read,
  output bwi_pkg::hist_t             rec
);
  import bwi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec <= '0;
    else if (complete) rec <= '{valid: 1'b1, hi: hi, prog: prog, read: read};
  end

  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !complete |=> $stable(rec));

endmodule

// File: rtl/bwi_wait_ctl.sv
module bwi_wait_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic need_wait,
  input  logic bus_off,
  output logic ready,
  output logic wait_q,
  output logic complete,
  output logic bus_en
);
  logic off_block;

  // An access already in its wait cycle is allowed to finish.
  assign off_block = bus_off && !wait_q;
  assign ready     = req && !off_block && (wait_q || !need_wait);
  assign complete  = req && ready;
  assign bus_en    = !bus_off || wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= 1'b0;
    else if (complete) wait_q <= 1'b0;
    else if (req && need_wait && !off_block) wait_q <= 1'b1;
  end

  assert_one_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && req) |-> ready);

  assert_wait_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && req) |=> !wait_q);

  assert_inflight_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> bus_en);

endmodule

// File: rtl/bank_wait_inserter.sv
module bank_wait_inserter #(
  parameter int         ADDR_W   = 16,
  parameter int         MMR_AW   = 8,
  parameter logic [7:0] CFG_ADDR = 8'h29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MMR_AW-1:0] mmr_addr,
  input  logic              mmr_wr,
  input  logic [15:0]       mmr_wdata,
  output logic [15:0]       mmr_rdata,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_prog,
  input  logic              acc_read,
  output logic              acc_ready,
  output logic              bus_en,
  output logic              hold_host_en,
  output logic              hold_data_en
);
  import bwi_pkg::*;

  logic [BANK_W-1:0] mask, hi;
  logic sw_en, bus_off, wait_q, complete;
  logic bank_ev, space_ev, switch_ev, need_wait;
  hist_t rec;

  assign hi = acc_addr[ADDR_W-1 -: BANK_W];

  bwi_cfg_reg #(.MMR_AW(MMR_AW), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .mmr_addr(mmr_addr), .mmr_wr(mmr_wr),
    .mmr_wdata(mmr_wdata), .mmr_rdata(mmr_rdata), .mask(mask), .sw_en(sw_en),
    .host_hold(hold_host_en), .data_hold(hold_data_en), .bus_off(bus_off)
  );

  bwi_history u_hist (
    .clk(clk), .rst_n(rst_n), .complete(complete), .hi(hi),
    .prog(acc_prog), .read(acc_read), .rec(rec)
  );

  // Named crossing events, visible to assertions.
  assign bank_ev   = bank_cross(rec, hi, acc_prog, mask);
  assign space_ev  = space_cross(rec, acc_prog);
  assign switch_ev = read_switch(rec, acc_prog, acc_read, sw_en);
  assign need_wait = bank_ev || space_ev || switch_ev;

  bwi_wait_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .req(acc_req), .need_wait(need_wait),
    .bus_off(bus_off), .ready(acc_ready), .wait_q(wait_q),
    .complete(complete), .bus_en(bus_en)
  );

  assert_first_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !rec.valid && !bus_off) |-> acc_ready);

  assert_space_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && space_ev && !wait_q) |-> !acc_ready);

  assert_bus_off_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !bus_en) |-> !acc_ready);

  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !bank_ev);

endmodule

// File: tb/bank_wait_inserter_bench.sv
module bank_wait_inserter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] mmr_addr = 8'h29;
  logic mmr_wr = 1'b0;
  logic [15:0] mmr_wdata = '0;
  logic [15:0] mmr_rdata;
  logic acc_req = 1'b0;
  logic [15:0] acc_addr = '0;
  logic acc_prog = 1'b0;
  logic acc_read = 1'b0;
  logic acc_ready, bus_en, hold_host_en, hold_data_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bank_wait_inserter u_bank_wait_inserter (
    .clk(clk), .rst_n(rst_n), .mmr_addr(mmr_addr), .mmr_wr(mmr_wr),
    .mmr_wdata(mmr_wdata), .mmr_rdata(mmr_rdata), .acc_req(acc_req),
    .acc_addr(acc_addr), .acc_prog(acc_prog), .acc_read(acc_read),
    .acc_ready(acc_ready), .bus_en(bus_en), .hold_host_en(hold_host_en),
    .hold_data_en(hold_data_en)
  );

  // {addr[15:0], prog, read, expected waits}
  localparam logic [18:0] VEC [12] = '{
    {16'h0100, 1'b0, 1'b1, 1'b0},  // R2 first access
    {16'h0200, 1'b0, 1'b1, 1'b0},  // same bank
    {16'h1200, 1'b0, 1'b1, 1'b1},  // R3 bank
    {16'h1300, 1'b1, 1'b1, 1'b1},  // R4+R5 together, R6 one wait
    {16'h1400, 1'b1, 1'b1, 1'b0},
    {16'h1500, 1'b0, 1'b1, 1'b1},  // R5 prog->data read
    {16'h1600, 1'b0, 1'b0, 1'b0},
    {16'h1700, 1'b1, 1'b0, 1'b1},  // R4 write
    {16'h1800, 1'b0, 1'b0, 1'b0},
    {16'h5000, 1'b0, 1'b0, 1'b1},  // R3
    {16'h5FFF, 1'b1, 1'b1, 1'b1},  // R4
    {16'h6000, 1'b1, 1'b1, 1'b1}   // R3 program space
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mmr_write(input logic [7:0] a, input logic [15:0] d);
    mmr_addr = a; mmr_wdata = d; mmr_wr = 1'b1;
    @(negedge clk);
    mmr_wr = 1'b0; mmr_addr = 8'h29;
  endtask

  // Issue one access at a negedge; count low-ready cycles; return at the
  // negedge after the completing edge.
  task automatic access(input logic [15:0] a, input logic p, input logic r,
                        output int waits);
    waits = 0;
    acc_req = 1'b1; acc_addr = a; acc_prog = p; acc_read = r;
    #1;
    while (!acc_ready && waits < 8) begin
      waits++;
      @(negedge clk); #1;
    end
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset word", mmr_rdata, 16'hF800);
    chk("R1 idle ready", acc_ready, 0);
    chk("R1 bus_en", bus_en, 1);
    chk("R8 holders reset", {hold_host_en, hold_data_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (VEC[i]) begin
      access(VEC[i][18:3], VEC[i][2], VEC[i][1], w);
      chk($sformatf("R3/R4/R5/R6 vector %0d waits", i), w, VEC[i][0]);
    end

    mmr_write(8'h29, 16'hF000);         // R5 switch off
    access(16'h6001, 1'b1, 1'b1, w);
    chk("R5 same-space read", w, 0);
    access(16'h6002, 1'b0, 1'b1, w);
    chk("R5 switch disabled", w, 0);

    mmr_write(8'h29, 16'h0000);         // R3 mask zero
    access(16'h9000, 1'b0, 1'b1, w);
    chk("R3 zero mask no bank wait", w, 0);
    mmr_write(8'h29, 16'h8000);
    access(16'hA000, 1'b0, 1'b1, w);
    chk("R3 masked bits equal", w, 0);
    access(16'h1000, 1'b0, 1'b1, w);
    chk("R3 masked msb differs", w, 1);

    mmr_write(8'h29, 16'hFFFF);         // R7 reserved ignored
    #1;
    chk("R7 reserved read zero", mmr_rdata, 16'hF807);
    chk("R8 holders on", {hold_host_en, hold_data_en}, 2'b11);
    mmr_write(8'h28, 16'h0000);
    #1;
    chk("R7 other address ignored", mmr_rdata, 16'hF807);
    mmr_addr = 8'h28; #1;
    chk("R7 other address reads 0", mmr_rdata, 0);
    mmr_addr = 8'h29;
    mmr_write(8'h29, 16'hF004);
    #1;
    chk("R8 host holder only", {hold_host_en, hold_data_en}, 2'b10);
    mmr_write(8'h29, 16'hF000);

    // R10: bank wait and bus-off write on the same edge.
    acc_req = 1'b1; acc_addr = 16'h2000; acc_prog = 1'b0; acc_read = 1'b1;
    mmr_wr = 1'b1; mmr_wdata = 16'hF001;
    #1;
    chk("R10 wait starts", acc_ready, 0);
    @(negedge clk);
    mmr_wr = 1'b0; #1;
    chk("R10 in-flight completes", acc_ready, 1);
    chk("R10 bus_en held", bus_en, 1);
    @(negedge clk);
    acc_req = 1'b0; #1;
    chk("R10 bus_en falls after", bus_en, 0);

    // R9: stall while bus-off.
    acc_req = 1'b1; acc_addr = 16'h2100; acc_prog = 1'b1; acc_read = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R9 stalled", acc_ready, 0);
      @(negedge clk);
    end
    mmr_wdata = 16'hF000; mmr_wr = 1'b1; #1;
    chk("R9 still stalled", acc_ready, 0);
    @(negedge clk);
    mmr_wr = 1'b0; #1;
    chk("R9 bus_en back", bus_en, 1);
    chk("R9 resumed access waits (R4)", acc_ready, 0);
    @(negedge clk); #1;
    chk("R9 resumed access completes", acc_ready, 1);
    @(negedge clk);
    acc_req = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule